// File: doc/BRIEF.md
# Multi-Channel Compare-Match Event Timer

This block is a 64-bit up-counter with a set of compare channels that raise interrupts when the counter reaches a programmed value. Software reaches it through a simple 32-bit register port. Every access is a single 32-bit word, and every access is answered one cycle later. A global register starts and stops the count. The count advances once per cycle in which `tick_en` is high. Each channel compares its 32-bit compare value against the low half of the counter.

A channel works in one of two modes. In one-shot mode it fires once and leaves its compare value alone. In periodic mode it adds its stored period to the compare value on each match. A channel signals either as a one-cycle pulse (edge type) or as a held level (level type). A level-type output stays high until software clears the channel's status bit. A separate `legacy_mute` output copies a global routing bit. Surrounding logic uses it to keep other timer interrupt sources quiet.

Map (byte offsets, word aligned):

| Offset | Register |
|---|---|
| 0x000 | identification word, reads 0x8086A201 |
| 0x004 | tick period in femtoseconds, reads 0x00989680 |
| 0x010 | global control |
| 0x020 | level status |
| 0x0F0 | counter bits 31:0 |
| 0x0F4 | counter bits 63:32 |
| 0x100 + 0x20*N | channel N registers, with sub-offsets +0x0 control, +0x4 routing capability, +0x8 compare, +0xC reserved |

Top module: `evt_timer_top`

## Requirements
- R1: `bus_ack` is high in the cycle after each cycle with `bus_valid` high, and low otherwise. On a read, `bus_rdata` carries the word in that same cycle. Offset 0x000 reads 0x8086A201 and offset 0x004 reads 0x00989680. Unmapped or unaligned offsets read 0 and ignore writes.
- R2: A write to 0x010 whose value is 0..3 sets run (bit 0) and route-mute (bit 1). A write with a larger value changes nothing. A read returns {mute, run} in bits 1:0. `legacy_mute` equals the mute bit.
- R3: While run is 1, the counter increases by one on each cycle with `tick_en` high. While run is 0, the counter holds its value. A read of 0x0F0 returns the current low 32 bits.
- R4: A write to 0x0F0 loads bits 31:0 only while run is 0, and is dropped while run is 1. A write to 0x0F4 always loads bits 63:32. A counter write takes priority over an increment in the same cycle.
- R5: Channel control reads back as follows: bit 1 level type, bit 2 interrupt enable, bit 3 periodic, bit 4 always 1, bits 13:9 route, bit 14 message delivery, all other bits 0. Offset +0x4 reads 0x000000FF and +0xC reads 0. After reset every compare value is 0xFFFFFFFF, channel 1 has route 8, and the other channels have route 0.
- R6: A channel control write with bit 0 set is ignored in full.
- R7: A match occurs on the increment that makes the counter's low half equal the compare value. On a match, an enabled edge-type channel drives its `irq_out` bit high for exactly one cycle, starting in the cycle after that clock edge.
- R8: Writing the compare value also stores it as the period. On each match in periodic mode the compare value grows by the period. In one-shot mode the compare value is unchanged.
- R9: A channel interrupt appears only when both its interrupt enable and run are set. Clearing run drops a held level output one cycle after the write, and setting run again restores it.
- R10: A match sets a level-type channel's flag, but only when its interrupt enable is set. The flag reads in status bit N and holds `irq_out[N]` high. Writing 1 to status bit N clears the flag, while writing 0 has no effect. Edge-type channels always read 0 in the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance strobe |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access answered (one cycle after request) |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| irq_out | output | NUM_CH | Per-channel interrupt |
| legacy_mute | output | 1 | Request to silence other timer sources |

## Verification
The compare path is driven with several patterns.
- A one-shot edge channel checks that the pulse lands on the exact tick and lasts one cycle.
- A periodic channel runs with a random period over a fixed window. Its pulse count and final compare value separate correct reloading from no reload, or from a reload by the wrong amount.
- A channel with its enable cleared is checked for silence.
- A level channel is held, masked by run, restored, and then cleared with a wrong-bit and a right-bit status write. This separates write-1-to-clear behaviour from plain writes.

Counter loads use a random base and a value just below the 32-bit boundary, which exposes a broken carry into the upper half. The reserved-bit and oversize-value writes confirm that rejected writes leave every field untouched.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int DATA_W  = 32;
  localparam int ROUTE_W = 5;

  localparam logic [31:0] ID_WORD   = 32'h8086_A201;
  localparam logic [31:0] TICK_FS   = 32'h0098_9680;
  localparam logic [31:0] ROUTE_CAP = 32'h0000_00FF;

  localparam logic [11:0] A_ID      = 12'h000;
  localparam logic [11:0] A_TICK    = 12'h004;
  localparam logic [11:0] A_GCTL    = 12'h010;
  localparam logic [11:0] A_STAT    = 12'h020;
  localparam logic [11:0] A_CNT_LO  = 12'h0F0;
  localparam logic [11:0] A_CNT_HI  = 12'h0F4;
  localparam logic [11:0] A_CH_BASE = 12'h100;
  localparam int          CH_SPAN_LG = 5;

  typedef struct packed {
    logic               msg;
    logic [ROUTE_W-1:0] route;
    logic               periodic;
    logic               ien;
    logic               level;
  } ch_ctl_t;

  typedef enum logic [1:0] {
    CR_CTL  = 2'd0,
    CR_CAPS = 2'd1,
    CR_CMP  = 2'd2,
    CR_RSVD = 2'd3
  } ch_reg_e;

  function automatic logic [ROUTE_W-1:0] reset_route(input int idx);
    return (idx == 1) ? ROUTE_W'(8) : '0;
  endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W  = 64,
  parameter int HALF_W = 32,
  localparam int HI_W  = CNT_W - HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              inc,
  output logic [HALF_W-1:0] next_lo
);
  logic [CNT_W-1:0] sum;

  assign inc     = run & tick_en;
  assign sum     = cnt_q + CNT_W'(1);
  assign next_lo = sum[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_hi) begin
      cnt_q <= {wdata[HI_W-1:0], cnt_q[HALF_W-1:0]};
    end else if (wr_lo) begin
      cnt_q <= {cnt_q[CNT_W-1:HALF_W], wdata};
    end else if (inc) begin
      cnt_q <= sum;
    end
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter int                 W           = 32,
  parameter logic [ROUTE_W-1:0] RESET_ROUTE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         glb_run,
  input  logic         inc,
  input  logic [W-1:0] cnt_next,
  input  logic         ctl_we,
  input  ch_ctl_t      ctl_wd,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wd,
  input  logic         clr,
  output logic [W-1:0] ctl_rd,
  output logic [W-1:0] cmp_q,
  output logic         flag_rd,
  output logic         irq_q
);
  ch_ctl_t     ctl_q;
  logic [W-1:0] period_q;
  logic        act_q, act_d, hit;

  assign hit = inc && (cnt_next == cmp_q);

  // flag: a new match wins over a clear in the same cycle
  always_comb begin
    act_d = act_q;
    if (clr) act_d = 1'b0;
    if (hit && ctl_q.ien && ctl_q.level) act_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q       <= '0;
      ctl_q.route <= RESET_ROUTE;
      cmp_q       <= '1;
      period_q    <= '0;
      act_q       <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wd;
      if (cmp_we) begin
        cmp_q    <= cmp_wd;
        period_q <= cmp_wd;
      end else if (hit && ctl_q.periodic) begin
        cmp_q <= cmp_q + period_q;
      end
      act_q <= act_d;
      irq_q <= glb_run && ctl_q.ien &&
               ((hit && !ctl_q.level) || (act_d && ctl_q.level));
    end
  end

  always_comb begin
    ctl_rd                 = '0;
    ctl_rd[1]              = ctl_q.level;
    ctl_rd[2]              = ctl_q.ien;
    ctl_rd[3]              = ctl_q.periodic;
    ctl_rd[4]              = 1'b1;
    ctl_rd[9 +: ROUTE_W]   = ctl_q.route;
    ctl_rd[14]             = ctl_q.msg;
  end

  assign flag_rd = act_q & ctl_q.level;
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import evt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 64,
  localparam int IDX_W = 12 - CH_SPAN_LG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_out,
  output logic              legacy_mute
);
  logic [11:0]       a12;
  logic              aligned, wr, in_ch, ch_sub_ok;
  logic [IDX_W-1:0]  ch_idx;
  ch_reg_e           ch_reg;
  ch_ctl_t           ctl_wd;

  logic              gen_en;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_inc;
  logic [DATA_W-1:0] cnt_next_lo;
  logic              wr_lo, wr_hi;

  logic [DATA_W-1:0] ch_ctl_rd [NUM_CH];
  logic [DATA_W-1:0] ch_cmp_rd [NUM_CH];
  logic [NUM_CH-1:0] chan_active;
  logic [NUM_CH-1:0] ctl_we, cmp_we, clr;
  logic [DATA_W-1:0] rd_mux;

  // ---------------- decode ----------------
  assign a12       = 12'(bus_addr);
  assign aligned   = (a12[1:0] == 2'b00);
  assign wr        = bus_valid & bus_write & aligned;
  assign in_ch     = (a12 >= A_CH_BASE) &&
                     (a12 < A_CH_BASE + 12'(NUM_CH << CH_SPAN_LG));
  assign ch_idx    = a12[11:CH_SPAN_LG] - IDX_W'(A_CH_BASE >> CH_SPAN_LG);
  assign ch_sub_ok = in_ch && !a12[4];
  assign ch_reg    = ch_reg_e'(a12[3:2]);

  assign ctl_wd.msg      = bus_wdata[14];
  assign ctl_wd.route    = bus_wdata[9 +: ROUTE_W];
  assign ctl_wd.periodic = bus_wdata[3];
  assign ctl_wd.ien      = bus_wdata[2];
  assign ctl_wd.level    = bus_wdata[1];

  assign wr_lo = wr && (a12 == A_CNT_LO) && !gen_en;
  assign wr_hi = wr && (a12 == A_CNT_HI);

  // ---------------- global control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en      <= 1'b0;
      legacy_mute <= 1'b0;
    end else if (wr && (a12 == A_GCTL) && (bus_wdata <= DATA_W'(3))) begin
      gen_en      <= bus_wdata[0];
      legacy_mute <= bus_wdata[1];
    end
  end

  // ---------------- counter ----------------
  evt_counter #(.CNT_W(CNT_W), .HALF_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (gen_en),
    .tick_en (tick_en),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wdata   (bus_wdata),
    .cnt_q   (cnt_q),
    .inc     (cnt_inc),
    .next_lo (cnt_next_lo)
  );

  // ---------------- channels ----------------
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel       = wr && ch_sub_ok && (ch_idx == IDX_W'(g));
    assign ctl_we[g] = sel && (ch_reg == CR_CTL) && !bus_wdata[0];
    assign cmp_we[g] = sel && (ch_reg == CR_CMP);
    assign clr[g]    = wr && (a12 == A_STAT) && bus_wdata[g];

    evt_channel #(.W(DATA_W), .RESET_ROUTE(reset_route(g))) u_ch (
      .clk      (clk),
      .rst      (rst),
      .glb_run  (gen_en),
      .inc      (cnt_inc),
      .cnt_next (cnt_next_lo),
      .ctl_we   (ctl_we[g]),
      .ctl_wd   (ctl_wd),
      .cmp_we   (cmp_we[g]),
      .cmp_wd   (bus_wdata),
      .clr      (clr[g]),
      .ctl_rd   (ch_ctl_rd[g]),
      .cmp_q    (ch_cmp_rd[g]),
      .flag_rd  (chan_active[g]),
      .irq_q    (irq_out[g])
    );
  end

  // ---------------- read mux ----------------
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (a12)
        A_ID:     rd_mux = ID_WORD;
        A_TICK:   rd_mux = TICK_FS;
        A_GCTL:   rd_mux = {30'd0, legacy_mute, gen_en};
        A_STAT:   rd_mux = DATA_W'(chan_active);
        A_CNT_LO: rd_mux = cnt_q[DATA_W-1:0];
        A_CNT_HI: rd_mux = cnt_q[CNT_W-1:DATA_W];
        default: begin
          for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sub_ok && (ch_idx == IDX_W'(i))) begin
              case (ch_reg)
                CR_CTL:  rd_mux = ch_ctl_rd[i];
                CR_CAPS: rd_mux = ROUTE_CAP;
                CR_CMP:  rd_mux = ch_cmp_rd[i];
                default: rd_mux = '0;
              endcase
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_valid;
      bus_rdata <= (bus_valid && !bus_write) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic [NUM_CH-1:0] irq_out,
  input logic              legacy_mute,
  input logic              gen_en,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [NUM_CH-1:0] chan_active
);
  logic cnt_wr, lo_wr, gctl_bad, stat_wr;
  assign cnt_wr   = bus_valid && bus_write &&
                    (12'(bus_addr) == 12'h0F0 || 12'(bus_addr) == 12'h0F4);
  assign lo_wr    = bus_valid && bus_write && (12'(bus_addr) == 12'h0F0);
  assign gctl_bad = bus_valid && bus_write && (12'(bus_addr) == 12'h010) &&
                    (bus_wdata > 32'd3);
  assign stat_wr  = bus_valid && bus_write && (12'(bus_addr) == 12'h020);

  p_ack_follows_r1: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> bus_ack);
  p_ack_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !bus_ack);
  p_bad_gctl_r2: assert property (@(posedge clk) disable iff (rst)
    gctl_bad |=> ($stable(legacy_mute) && $stable(gen_en)));
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!gen_en && !cnt_wr) |=> $stable(cnt_q));
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    (gen_en && tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_lo_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (gen_en && lo_wr && !tick_en) |=> $stable(cnt_q));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    p_irq_needs_run_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_out[g]) |-> $past(gen_en));
    p_flag_held_r10: assert property (@(posedge clk) disable iff (rst)
      (chan_active[g] && !(stat_wr && bus_wdata[g])) |=> chan_active[g]);
  end
endmodule

bind evt_timer_top evt_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/evt_timer_top_tb.sv
module evt_timer_top_tb;
  localparam int NUM_CH = 3;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst, tick_en, bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              bus_ack, legacy_mute;
  logic [NUM_CH-1:0] irq_out;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  evt_timer_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .legacy_mute(legacy_mute));

  function automatic logic [31:0] exp_ctl(input bit lvl, input bit ien,
                                          input bit per, input int route);
    return 32'(lvl) << 1 | 32'(ien) << 2 | 32'(per) << 3 | 32'h10 |
           (32'(route) & 32'h1F) << 9;
  endfunction

  function automatic int exp_pulses(input int period, input int ticks);
    return ticks / period;
  endfunction

  function automatic logic [11:0] ch_addr(input int ch, input int sub);
    return 12'h100 + 12'(ch * 32 + sub);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = ADDR_W'(a); bus_wdata = '0;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
    if (bus_ack !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R1 ack: actual %0b expected 1", bus_ack);
    end
  endtask

  task automatic tick();
    tick_en = 1;
    @(negedge clk);
    tick_en = 0;
  endtask

  task automatic zero_counter();
    wr(12'h010, 32'd0);
    wr(12'h0F0, 32'd0);
    wr(12'h0F4, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, base, hi;
    int p, cnt, seedv;
    seedv = int'($urandom(32'h5EED_0042));
    rst = 1; tick_en = 0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state
    chk("R1 ack idle", 64'(bus_ack), 0);
    chk("R9 irq reset", 64'(irq_out), 0);
    chk("R2 mute reset", 64'(legacy_mute), 0);
    rd(12'h000, d); chk("R1 id word", 64'(d), 64'h8086A201);
    rd(12'h004, d); chk("R1 tick period", 64'(d), 64'h00989680);
    rd(12'h010, d); chk("R2 gctl reset", 64'(d), 0);
    rd(12'h0F0, d); chk("R3 cnt reset", 64'(d), 0);
    rd(ch_addr(0, 0), d); chk("R5 ch0 ctl reset", 64'(d), 64'(exp_ctl(0, 0, 0, 0)));
    rd(ch_addr(1, 0), d); chk("R5 ch1 route 8", 64'(d), 64'(exp_ctl(0, 0, 0, 8)));
    rd(ch_addr(2, 8), d); chk("R5 ch2 cmp reset", 64'(d), 64'hFFFFFFFF);
    rd(ch_addr(0, 4), d); chk("R5 route caps", 64'(d), 64'hFF);
    rd(ch_addr(0, 12), d); chk("R5 rsvd zero", 64'(d), 0);
    rd(12'h030, d); chk("R1 unmapped", 64'(d), 0);
    rd(12'h012, d); chk("R1 unaligned", 64'(d), 0);

    // global control
    wr(12'h010, 32'd6);
    rd(12'h010, d); chk("R2 oversize ignored", 64'(d), 0);
    chk("R2 mute after oversize", 64'(legacy_mute), 0);
    wr(12'h010, 32'd2);
    rd(12'h010, d); chk("R2 mute readback", 64'(d), 2);
    chk("R2 mute pin", 64'(legacy_mute), 1);
    wr(12'h010, 32'd0);

    // counter load, run, carry
    base = $urandom % 32'h1000_0000;
    hi   = $urandom;
    wr(12'h0F0, base);
    wr(12'h0F4, hi);
    rd(12'h0F0, d); chk("R4 lo load", 64'(d), 64'(base));
    rd(12'h0F4, d); chk("R4 hi load", 64'(d), 64'(hi));
    wr(12'h010, 32'd1);
    cnt = 1 + int'($urandom % 20);
    for (int i = 0; i < cnt; i++) tick();
    rd(12'h0F0, d); chk("R3 count ticks", 64'(d), 64'(base + 32'(cnt)));
    wr(12'h0F0, 32'h1234);
    rd(12'h0F0, d); chk("R4 lo drop while run", 64'(d), 64'(base + 32'(cnt)));
    wr(12'h010, 32'd0);
    repeat (4) tick();
    rd(12'h0F0, d); chk("R3 hold while stopped", 64'(d), 64'(base + 32'(cnt)));
    wr(12'h0F0, 32'hFFFF_FFFE);
    wr(12'h0F4, 32'h0000_0007);
    wr(12'h010, 32'd1);
    repeat (3) tick();
    rd(12'h0F0, d); chk("R3 carry lo", 64'(d), 1);
    rd(12'h0F4, d); chk("R3 carry hi", 64'(d), 8);

    // control write with reserved bit
    wr(ch_addr(0, 0), 32'h0000_000D);
    rd(ch_addr(0, 0), d); chk("R6 reserved bit ignored", 64'(d), 64'(exp_ctl(0, 0, 0, 0)));
    wr(ch_addr(0, 0), 32'h0000_4604);
    rd(ch_addr(0, 0), d); chk("R5 ctl fields", 64'(d), 64'(32'h4000 | exp_ctl(0, 1, 0, 3)));

    // one-shot edge
    zero_counter();
    wr(ch_addr(0, 0), exp_ctl(0, 1, 0, 0));
    wr(ch_addr(0, 8), 32'd10);
    wr(12'h010, 32'd1);
    cnt = 0;
    for (int i = 0; i < 9; i++) begin tick(); if (irq_out[0]) cnt++; end
    chk("R7 no early pulse", 64'(cnt), 0);
    tick();
    chk("R7 pulse on match", 64'(irq_out[0]), 1);
    @(negedge clk);
    chk("R7 pulse one cycle", 64'(irq_out[0]), 0);
    rd(ch_addr(0, 8), d); chk("R8 one-shot cmp kept", 64'(d), 10);
    rd(12'h020, d); chk("R10 edge status zero", 64'(d), 0);

    // periodic edge, random period
    zero_counter();
    p = 2 + int'($urandom % 8);
    wr(ch_addr(1, 0), exp_ctl(0, 1, 1, 8));
    wr(ch_addr(1, 8), 32'(p));
    wr(12'h010, 32'd1);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (irq_out[1]) cnt++; end
    chk("R8 periodic pulses", 64'(cnt), 64'(exp_pulses(p, 40)));
    rd(ch_addr(1, 8), d); chk("R8 periodic cmp", 64'(d), 64'(p * (exp_pulses(p, 40) + 1)));

    // interrupt enable gating
    zero_counter();
    wr(ch_addr(0, 0), exp_ctl(0, 0, 0, 0));
    wr(ch_addr(0, 8), 32'd5);
    wr(12'h010, 32'd1);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin tick(); if (irq_out[0]) cnt++; end
    chk("R9 disabled channel silent", 64'(cnt), 0);

    // level channel
    zero_counter();
    wr(ch_addr(1, 0), exp_ctl(0, 0, 0, 8));
    wr(ch_addr(2, 0), exp_ctl(1, 1, 0, 0));
    wr(ch_addr(2, 8), 32'd3);
    wr(12'h010, 32'd1);
    tick(); tick();
    chk("R10 level not yet", 64'(irq_out[2]), 0);
    tick();
    chk("R10 level asserted", 64'(irq_out[2]), 1);
    tick(); tick();
    chk("R10 level held", 64'(irq_out[2]), 1);
    rd(12'h020, d); chk("R10 status bit", 64'(d), 4);
    wr(12'h010, 32'd0);
    @(negedge clk);
    chk("R9 run off masks level", 64'(irq_out[2]), 0);
    wr(12'h010, 32'd1);
    @(negedge clk);
    chk("R9 run on restores level", 64'(irq_out[2]), 1);
    wr(12'h020, 32'd3);
    chk("R10 wrong bit no clear", 64'(irq_out[2]), 1);
    rd(12'h020, d); chk("R10 status after zero write", 64'(d), 4);
    wr(12'h020, 32'd4);
    chk("R10 w1c drops level", 64'(irq_out[2]), 0);
    rd(12'h020, d); chk("R10 status cleared", 64'(d), 0);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule